// File: doc/BRIEF.md
# Extended Unsigned 128-by-64 Divider

This block divides a 128-bit unsigned value by a 64-bit unsigned divisor. The dividend is never supplied whole. The single 64-bit source operand becomes its upper half, and the lower half is all zeros. One restoring shift-and-subtract step runs per clock, so a full division takes one iteration per quotient bit. The block returns a 64-bit quotient and exposes the final partial remainder.

A division overflows when the divisor is zero or when the true quotient needs more than 64 bits. Because the lower dividend half is zero, both cases reduce to the operand being greater than or equal to the divisor. The block detects this before iterating, forces the quotient to zero and finishes at once. It keeps an overflow flag and a sticky summary-overflow flag, which change only when overflow checking is requested for that operation. A record request loads a 3-bit sign/zero field from the quotient.

Operations pass through a start/busy/done handshake. An operation is accepted on a clock edge where `startIn` is high and `busy` is low. `done` is a one-cycle pulse, and in that cycle every result output is valid.

Top module: `xdiv_top`

## Requirements
- R1: After reset, `busy`, `done`, `quotient`, `ovFlag`, `sumOvFlag` and `crField` are all zero.
- R2: With `divisor` nonzero and `operandA < divisor`, the operation returns `quotient` = floor((operandA·2^64)/divisor) and `remainder` = (operandA·2^64) mod divisor. `done` rises 65 cycles after the accepting edge, counting that edge's cycle as cycle 1.
- R3: With `divisor` = 0 or `operandA >= divisor`, the operation overflows: `quotient` is 0 and `done` is high in the cycle right after the accepting edge.
- R4: When `ovCheckEn` is 1 at start and the operation overflows, `ovFlag` and `sumOvFlag` are both 1 at `done`.
- R5: When `ovCheckEn` is 1 at start and the operation does not overflow, `ovFlag` is 0 at `done` and `sumOvFlag` keeps its earlier value. `sumOvFlag` never clears except by reset.
- R6: When `ovCheckEn` is 0 at start, `ovFlag` and `sumOvFlag` keep their earlier values.
- R7: When `recordEn` is 1 at start, `crField` at `done` is {lt, gt, eq}: bit 2 means the quotient is negative as a signed 64-bit value, bit 1 means it is positive, and bit 0 means it is zero. When `recordEn` is 0, `crField` keeps its earlier value.
- R8: `done` lasts exactly one cycle and is followed by `busy` low. `startIn` is ignored while `busy` is high, and the running operation's results are unaffected by it.
- R9: An operand of zero with a nonzero divisor does not overflow and returns a quotient of 0 and a remainder of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start request, accepted only when busy is low |
| operandA | input | 64 | Upper half of the dividend |
| divisor | input | 64 | Divisor |
| ovCheckEn | input | 1 | Update the overflow flags for this operation |
| recordEn | input | 1 | Update the condition field for this operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 64 | Quotient, forced to zero on overflow |
| remainder | output | 64 | Final partial remainder |
| ovFlag | output | 1 | Overflow of the last checked operation |
| sumOvFlag | output | 1 | Sticky summary overflow |
| crField | output | 3 | {lt, gt, eq} of the last recorded quotient |

## Verification
A wrong quotient bit on any iteration shows up as a wrong `quotient` in the `done` cycle, 65 cycles after start. It usually also leaves a `remainder` that is not smaller than the divisor. A miscounted iteration counter moves the `done` cycle, and the bench measures that cycle exactly. A misrouted overflow decision shows at once: either `done` arrives one cycle after start with a zero quotient where a real quotient was expected, or the reverse. A flag written under the wrong enable only shows at the next `done`, when `ovFlag`, `sumOvFlag` or `crField` differ from the model the bench keeps across operations.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

  // Strobes issued by the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic load;    // capture operands, start a new operation
    logic step;    // one shift-and-subtract iteration
    logic commit;  // write quotient and flags this cycle
    logic ovCase;  // the operation being committed overflowed
  } xdivStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xdivState_t;

endpackage

// File: rtl/xdiv_ctrl.sv
module xdiv_ctrl
  import xdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        earlyOv,
  output logic        busy,
  output logic        done,
  output xdivStrobe_t strb
);

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(W - 1);

  xdivState_t state, stateNx;
  logic [CNT_W-1:0] iterCnt;
  logic accept;
  logic lastIter;

  assign accept   = startIn && (state == ST_IDLE);
  assign lastIter = (iterCnt == LAST_ITER);

  always_comb begin
    stateNx     = state;
    strb.load   = 1'b0;
    strb.step   = 1'b0;
    strb.commit = 1'b0;
    strb.ovCase = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          strb.load = 1'b1;
          if (earlyOv) begin
            strb.commit = 1'b1;
            strb.ovCase = 1'b1;
            stateNx     = ST_FIN;
          end else begin
            stateNx = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strb.step = 1'b1;
        if (lastIter) begin
          strb.commit = 1'b1;
          stateNx     = ST_FIN;
        end
      end
      ST_FIN:  stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      state <= stateNx;
      if (strb.load)      iterCnt <= '0;
      else if (strb.step) iterCnt <= iterCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busy) |=> busy); // R8

  AST_EARLY_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busy && earlyOv) |=> done); // R3

  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busy && !earlyOv) |=> !done); // R2

endmodule

// File: rtl/xdiv_datapath.sv
module xdiv_datapath
  import xdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  xdivStrobe_t  strb,
  input  logic [W-1:0] operandA,
  input  logic [W-1:0] divisor,
  input  logic         ovCheckEn,
  input  logic         recordEn,
  output logic         earlyOv,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         ovFlag,
  output logic         sumOvFlag,
  output logic [2:0]   crField
);

  logic [W-1:0] hiReg, loReg, divReg;
  logic         chkLat, recLat;
  logic         iterating;

  // One restoring iteration on the {hi, lo} pair.
  logic         carryOut;
  logic [W-1:0] hiShift, hiNx, loNx;
  logic         takeSub;

  assign carryOut = hiReg[W-1];
  assign hiShift  = {hiReg[W-2:0], loReg[W-1]};
  assign takeSub  = carryOut || (hiShift >= divReg);
  assign hiNx     = takeSub ? (hiShift - divReg) : hiShift;
  assign loNx     = {loReg[W-2:0], takeSub};

  // With a zero lower dividend half, the quotient fits only when hi < div.
  // A zero divisor is caught by the same compare.
  assign earlyOv = (operandA >= divisor);

  logic         chkEff, recEff;
  logic [W-1:0] resNx;
  logic [2:0]   crNx;

  assign chkEff = strb.load ? ovCheckEn : chkLat;
  assign recEff = strb.load ? recordEn  : recLat;
  assign resNx  = strb.ovCase ? '0 : loNx;

  always_comb begin
    crNx = 3'b000;
    if (resNx == '0)       crNx[0] = 1'b1;
    else if (resNx[W-1])   crNx[2] = 1'b1;
    else                   crNx[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg     <= '0;
      loReg     <= '0;
      divReg    <= '0;
      chkLat    <= 1'b0;
      recLat    <= 1'b0;
      iterating <= 1'b0;
    end else begin
      if (strb.load) begin
        hiReg     <= operandA;
        loReg     <= '0;
        divReg    <= divisor;
        chkLat    <= ovCheckEn;
        recLat    <= recordEn;
        iterating <= !strb.commit;
      end else if (strb.step) begin
        hiReg <= hiNx;
        loReg <= loNx;
        if (strb.commit) iterating <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotient  <= '0;
      ovFlag    <= 1'b0;
      sumOvFlag <= 1'b0;
      crField   <= 3'b000;
    end else if (strb.commit) begin
      quotient <= resNx;
      if (chkEff) begin
        ovFlag    <= strb.ovCase;
        sumOvFlag <= sumOvFlag | strb.ovCase;
      end
      if (recEff) crField <= crNx;
    end
  end

  assign remainder = hiReg;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    iterating |-> (hiReg < divReg)); // R2

  AST_SUMOV_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    sumOvFlag |=> sumOvFlag); // R5

  AST_OV_IMPLIES_SUMOV: assert property (@(posedge clk) disable iff (!rstN)
    ovFlag |-> sumOvFlag); // R4

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(ovFlag) && $stable(sumOvFlag) && $stable(crField))); // R6

  AST_CR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(crField)); // R7

endmodule

// File: rtl/xdiv_top.sv
module xdiv_top
  import xdiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic [W-1:0] operandA,
  input  logic [W-1:0] divisor,
  input  logic         ovCheckEn,
  input  logic         recordEn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         ovFlag,
  output logic         sumOvFlag,
  output logic [2:0]   crField
);

  xdivStrobe_t strb;
  logic        earlyOv;

  xdiv_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .earlyOv (earlyOv),
    .busy    (busy),
    .done    (done),
    .strb    (strb)
  );

  xdiv_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .operandA  (operandA),
    .divisor   (divisor),
    .ovCheckEn (ovCheckEn),
    .recordEn  (recordEn),
    .earlyOv   (earlyOv),
    .quotient  (quotient),
    .remainder (remainder),
    .ovFlag    (ovFlag),
    .sumOvFlag (sumOvFlag),
    .crField   (crField)
  );

  AST_OV_ZERO_QUOT: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(earlyOv) && $past(startIn)) |-> (quotient == '0)); // R3

endmodule

// File: tb/xdiv_top_bench.sv
`timescale 1ns/1ps
module xdiv_top_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic [W-1:0] operandA = '0;
  logic [W-1:0] divisor = '0;
  logic         ovCheckEn = 1'b0;
  logic         recordEn = 1'b0;
  logic         busy, done, ovFlag, sumOvFlag;
  logic [W-1:0] quotient, remainder;
  logic [2:0]   crField;

  int nTests = 0;
  int nFails = 0;
  int cycles = 0;

  // Bench-side model of the flag state across operations.
  logic       mOv = 1'b0;
  logic       mSo = 1'b0;
  logic [2:0] mCr = 3'b000;

  always #2.5 clk = ~clk;

  xdiv_top #(.W(W)) u_xdiv_top (
    .clk(clk), .rstN(rstN), .startIn(startIn), .operandA(operandA),
    .divisor(divisor), .ovCheckEn(ovCheckEn), .recordEn(recordEn),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .ovFlag(ovFlag), .sumOvFlag(sumOvFlag), .crField(crField)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nTests = nTests + 1;
    if (!ok) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] crOf(input logic [W-1:0] q);
    if (q == '0) return 3'b001;
    if (q[W-1])  return 3'b100;
    return 3'b010;
  endfunction

  // One full handshake; returns the done-cycle latency.
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] d,
                       input bit chk, input bit rec, output int lat);
    @(negedge clk);
    operandA = a; divisor = d; ovCheckEn = chk; recordEn = rec; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat = lat + 1;
    end
  endtask

  // Compute expected results, update model, compare at done.
  task automatic checkOp(input logic [W-1:0] a, input logic [W-1:0] d,
                         input bit chk, input bit rec, input string tag);
    logic [2*W-1:0] dvd, q128, r128;
    logic [W-1:0]   eq, er;
    bit             ov;
    int             lat;
    dvd = {a, {W{1'b0}}};
    ov  = (d == '0) || (a >= d);
    if (!ov) begin
      q128 = dvd / {{W{1'b0}}, d};
      r128 = dvd % {{W{1'b0}}, d};
      eq = q128[W-1:0];
      er = r128[W-1:0];
    end else begin
      eq = '0;
      er = '0;
    end
    if (chk) begin
      mOv = ov;
      mSo = mSo | ov;
    end
    if (rec) mCr = crOf(eq);
    runOp(a, d, chk, rec, lat);
    check(lat == (ov ? 1 : W + 1), {tag, " latency R2/R3"}, lat, ov ? 1 : W + 1);
    check(quotient == eq, {tag, (ov ? " quotient R3" : " quotient R2")}, quotient, eq);
    if (!ov) check(remainder == er, {tag, " remainder R2"}, remainder, er);
    check(ovFlag == mOv, {tag, (chk ? (ov ? " ovFlag R4" : " ovFlag R5") : " ovFlag R6")},
          W'(ovFlag), W'(mOv));
    check(sumOvFlag == mSo, {tag, (chk ? (ov ? " sumOv R4" : " sumOv R5") : " sumOv R6")},
          W'(sumOvFlag), W'(mSo));
    check(crField == mCr, {tag, " crField R7"}, W'(crField), W'(mCr));
    @(negedge clk);
    check(!done && !busy, {tag, " done pulse R8"}, W'({done, busy}), '0);
  endtask

  task automatic tReset();
    check(!busy && !done, "reset handshake R1", W'({busy, done}), '0);
    check(quotient == '0, "reset quotient R1", quotient, '0);
    check({ovFlag, sumOvFlag, crField} == 5'b0, "reset flags R1",
          W'({ovFlag, sumOvFlag, crField}), '0);
  endtask

  task automatic tNormal();
    checkOp(64'd1, 64'd3, 1'b0, 1'b0, "one_by_three");
    checkOp(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211, 1'b0, 1'b0, "mixed");
    checkOp(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "near_max");
    checkOp(64'd7, 64'h8000_0000_0000_0001, 1'b0, 1'b0, "big_div");
  endtask

  task automatic tOverflow();
    checkOp(64'd5, 64'd0, 1'b0, 1'b0, "div_zero_nochk");
    checkOp(64'd9, 64'd9, 1'b1, 1'b0, "equal_chk");
    checkOp(64'd1, 64'd3, 1'b1, 1'b0, "clear_ov_keep_so");
    checkOp(64'hFFFF, 64'd2, 1'b0, 1'b0, "ov_nochk_hold");
    checkOp(64'd0, 64'd0, 1'b1, 1'b1, "zero_by_zero");
  endtask

  task automatic tRecord();
    checkOp(64'd1, 64'd2, 1'b0, 1'b1, "neg_quot");
    checkOp(64'd1, 64'd4, 1'b0, 1'b1, "pos_quot");
    checkOp(64'd3, 64'd1, 1'b0, 1'b1, "ov_zero_eq");
    checkOp(64'd1, 64'd2, 1'b0, 1'b0, "rec_off_hold");
  endtask

  task automatic tZeroOperand();
    checkOp(64'd0, 64'd12345, 1'b1, 1'b1, "zero_operand R9");
    check(remainder == '0, "zero remainder R9", remainder, '0);
  endtask

  task automatic tBusyIgnore();
    int lat;
    logic [W-1:0] expQ;
    expQ = 64'h5555_5555_5555_5555; // 1*2^64/3, quotient of the first operation
    @(negedge clk);
    operandA = 64'd1; divisor = 64'd3; ovCheckEn = 1'b0; recordEn = 1'b0; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (10) @(negedge clk);
    operandA = 64'd50; divisor = 64'd0; ovCheckEn = 1'b1; recordEn = 1'b1; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    lat = 12;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat = lat + 1;
    end
    check(lat == W + 1, "start while busy latency R8", lat, W + 1);
    check(quotient == expQ, "start while busy quotient R8", quotient, expQ);
    check({ovFlag, sumOvFlag, crField} == {mOv, mSo, mCr}, "start while busy flags R8",
          W'({ovFlag, sumOvFlag, crField}), W'({mOv, mSo, mCr}));
    @(negedge clk);
    check(!busy && !done, "idle after ignored start R8", W'({busy, done}), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tNormal();
    tOverflow();
    tRecord();
    tZeroOperand();
    tBusyIgnore();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule